// File: doc/BRIEF.md
# Programmable Look-Up Logic Cell

This block models one cell of a programmable logic fabric. A 16-bit truth table, loaded through a serial configuration port, turns four data bits into one output. The cell can therefore realise any Boolean function of four inputs. A mode bit switches the cell into arithmetic operation. In that mode the table is split into two 3-input halves: one half yields a sum bit and the other yields a carry bit. An add/subtract control inverts the second operand. Cells wired carry-out to carry-in form ripple adders and subtractors of any width.

Behind the table sits a single output flip-flop. It has a clock enable, a synchronous clear, a synchronous load and an active-low asynchronous clear. The flip-flop normally captures the table result. A configuration bit can make it capture a neighbouring cell's register instead, so adjacent cells form a shift register. Two more configuration bits let the carry-in and the register's own value stand in for table inputs.

Top module: `lut_cell`

## Requirements
- R1: While `cfg_en` is high, one bit of `cfg_din` is shifted in per clock, most significant bit first. The 20-bit word is, first to last: truth table bit 15 down to bit 0, arithmetic-mode bit, chain-select bit, carry-substitute bit, feedback bit. While `cfg_en` is low the configuration holds. `rst_n` low clears all 20 bits to zero.
- R2: With the arithmetic-mode bit at 0, `comb_out` equals truth-table bit number {data_in[3], data_in[2], data_in[1], data_in[0]}. `lut_chain_out` always equals `comb_out`. In this mode `cout` is 0.
- R3: In normal mode with the carry-substitute bit set, `cin` takes the place of data_in[2] in the table index, and data_in[2] has no effect.
- R4: In normal mode with the feedback bit set, `reg_out` takes the place of data_in[3] in the table index, and data_in[3] has no effect.
- R5: With the arithmetic-mode bit at 1, let b = data_in[1] XOR sub_en and let k = {cin, b, data_in[0]}. Then `comb_out` is table bit k and `cout` is table bit 8+k. The table value 16'hE896 gives sum = a XOR b XOR cin and cout = majority(a, b, cin).
- R6: Four cells in arithmetic mode with the adder table, chained carry-out to carry-in, with the first carry-in equal to `sub_en`, produce A+B (sum and carry) when adding. When subtracting they produce (A-B) mod 16, with a final carry of 1 exactly when A >= B.
- R7: On a rising edge with `clk_en` high and no load or clear, the register captures `comb_out` (chain-select 0). With `clk_en` low, the register holds whatever the other inputs do.
- R8: With `clk_en` high, `sclr` sets the register to 0 even when `sload` is also high. `sload` alone loads `load_val`.
- R9: With the chain-select bit set, the register captures `chain_in` instead of the table result. `chain_out` always equals `reg_out`.
- R10: `rst_n` low clears the register at once, without waiting for a clock edge and regardless of `clk_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous clear of register and configuration |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration data, MSB first |
| clk_en | input | 1 | Clock enable for the register's synchronous paths |
| data_in | input | 4 | Table data inputs |
| cin | input | 1 | Carry-in |
| sub_en | input | 1 | 1 = subtract (invert operand b) in arithmetic mode |
| sload | input | 1 | Synchronous load of `load_val` |
| sclr | input | 1 | Synchronous clear, wins over load |
| load_val | input | 1 | Value taken by a synchronous load |
| chain_in | input | 1 | Register-chain input from the neighbouring cell |
| comb_out | output | 1 | Combinational table result |
| lut_chain_out | output | 1 | Table result toward the next cell |
| cout | output | 1 | Carry-out |
| reg_out | output | 1 | Registered output |
| chain_out | output | 1 | Register-chain output toward the next cell |

## Verification
The bench sweeps every index of two unrelated truth tables. This catches a swapped index bit order, which would return the mirrored table entry. It also catches a wrong bit order in the serial shift, which would scramble the table. For the carry and feedback substitutions it toggles the displaced data input and shows that the output does not move. A cell that still read that pin would fail there.

A four-cell chain is run over all 256 operand pairs, both adding and subtracting. A missing operand inversion, or a first carry-in not tied to `sub_en`, would give results off by one or complemented. The register tests drive clear and load together to expose a reversed priority. They toggle inputs with the clock enable low to expose a leaking enable. They also drop the reset between edges to show the clear is asynchronous.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;
    localparam int LUT_K      = 4;
    localparam int TABLE_W    = 1 << LUT_K;
    localparam int HALF_W     = TABLE_W / 2;
    localparam int MODE_BITS  = 4;
    localparam int CFG_W      = TABLE_W + MODE_BITS;

    typedef struct packed {
        logic [TABLE_W-1:0] truth;
        logic               arith;
        logic               chain_sel;
        logic               cin_sel;
        logic               fb_sel;
    } cell_cfg_t;

    typedef struct packed {
        logic q;
    } cell_reg_t;
endpackage

// File: rtl/lut_cfg_store.sv
module lut_cfg_store
    import lut_cell_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cfg_en,
    input  logic      cfg_din,
    output cell_cfg_t cfg
);
    cell_cfg_t cfg_d, cfg_q;
    logic [CFG_W-1:0] raw_q;

    assign raw_q = cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_en) begin
            cfg_d = cell_cfg_t'({raw_q[CFG_W-2:0], cfg_din});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

    // R1: newest serial bit lands in the last configuration position
    p_cfg_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> raw_q[0] == $past(cfg_din));

    // R1: configuration frozen while the shift enable is low
    p_cfg_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(raw_q));
endmodule

// File: rtl/lut_eval.sv
module lut_eval
    import lut_cell_pkg::*;
(
    input  cell_cfg_t          cfg,
    input  logic [LUT_K-1:0]   data_in,
    input  logic               cin,
    input  logic               sub_en,
    input  logic               reg_fb,
    output logic               f_out,
    output logic               c_out
);
    localparam int HALF_IDX_W = LUT_K - 1;

    logic [LUT_K-1:0]      idx_norm;
    logic [HALF_IDX_W-1:0] idx_arith;
    logic                  b_eff;
    logic [HALF_W-1:0]     sum_half;
    logic [HALF_W-1:0]     carry_half;

    assign sum_half   = cfg.truth[HALF_W-1:0];
    assign carry_half = cfg.truth[TABLE_W-1:HALF_W];

    always_comb begin
        idx_norm    = data_in;
        if (cfg.cin_sel) idx_norm[2] = cin;
        if (cfg.fb_sel)  idx_norm[3] = reg_fb;

        b_eff     = data_in[1] ^ sub_en;
        idx_arith = {cin, b_eff, data_in[0]};

        if (cfg.arith) begin
            f_out = sum_half[idx_arith];
            c_out = carry_half[idx_arith];
        end else begin
            f_out = cfg.truth[idx_norm];
            c_out = 1'b0;
        end
    end
endmodule

// File: rtl/lut_out_reg.sv
module lut_out_reg
    import lut_cell_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic sclr,
    input  logic sload,
    input  logic load_val,
    input  logic chain_sel,
    input  logic chain_in,
    input  logic lut_val,
    output logic q
);
    cell_reg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clk_en) begin
            if (sclr) begin
                st_d.q = 1'b0;
            end else if (sload) begin
                st_d.q = load_val;
            end else if (chain_sel) begin
                st_d.q = chain_in;
            end else begin
                st_d.q = lut_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.q;

    // R8: clear wins over a simultaneous load
    p_sclr_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && sclr) |=> !q);

    // R8: load alone takes the load value
    p_sload_val_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !sclr && sload) |=> q == $past(load_val));

    // R7: disabled clock enable keeps the register
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(q));

    // R9: chain path captures the neighbour's register
    p_chain_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !sclr && !sload && chain_sel) |=> q == $past(chain_in));

    // R7: normal capture of the table result
    p_lut_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !sclr && !sload && !chain_sel) |=> q == $past(lut_val));
endmodule

// File: rtl/lut_cell.sv
module lut_cell
    import lut_cell_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_din,
    input  logic             clk_en,
    input  logic [LUT_K-1:0] data_in,
    input  logic             cin,
    input  logic             sub_en,
    input  logic             sload,
    input  logic             sclr,
    input  logic             load_val,
    input  logic             chain_in,
    output logic             comb_out,
    output logic             lut_chain_out,
    output logic             cout,
    output logic             reg_out,
    output logic             chain_out
);
    cell_cfg_t cfg;
    logic      f_val;
    logic      c_val;
    logic      q_val;

    lut_cfg_store u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_en  (cfg_en),
        .cfg_din (cfg_din),
        .cfg     (cfg)
    );

    lut_eval u_eval (
        .cfg     (cfg),
        .data_in (data_in),
        .cin     (cin),
        .sub_en  (sub_en),
        .reg_fb  (q_val),
        .f_out   (f_val),
        .c_out   (c_val)
    );

    lut_out_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .sclr      (sclr),
        .sload     (sload),
        .load_val  (load_val),
        .chain_sel (cfg.chain_sel),
        .chain_in  (chain_in),
        .lut_val   (f_val),
        .q         (q_val)
    );

    assign comb_out      = f_val;
    assign lut_chain_out = f_val;
    assign cout          = c_val;
    assign reg_out       = q_val;
    assign chain_out     = q_val;

    // R2: no carry leaves a cell in normal mode
    p_normal_no_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.arith |-> !cout);
endmodule

// File: tb/lut_cell_tb.sv
module lut_cell_tb;
    localparam int CLK_P  = 10;
    localparam int NCHAIN = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_din = 1'b0;
    logic cfg_en_s = 1'b0, cfg_en_c = 1'b0;

    logic       clk_en = 1'b0, sload = 1'b0, sclr = 1'b0, load_val = 1'b0;
    logic [3:0] d = '0;
    logic       cin = 1'b0, sub = 1'b0, chin = 1'b0;
    logic       comb_out, lchain, cout, reg_out, chain_out;

    logic [NCHAIN-1:0] op_a = '0, op_b = '0;
    logic              c_sub = 1'b0, c_en = 1'b0, c_ser = 1'b0;
    logic [NCHAIN-1:0] c_sum, c_co, c_q, c_lc;
    logic [NCHAIN:0]   c_ci;
    logic [NCHAIN:0]   c_ch;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    lut_cell u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en_s), .cfg_din(cfg_din),
        .clk_en(clk_en), .data_in(d), .cin(cin), .sub_en(sub),
        .sload(sload), .sclr(sclr), .load_val(load_val), .chain_in(chin),
        .comb_out(comb_out), .lut_chain_out(lchain), .cout(cout),
        .reg_out(reg_out), .chain_out(chain_out)
    );

    assign c_ci[0] = c_sub;
    assign c_ch[0] = c_ser;

    for (genvar k = 0; k < NCHAIN; k++) begin : g_chain
        lut_cell u_cell (
            .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en_c), .cfg_din(cfg_din),
            .clk_en(c_en), .data_in({2'b00, op_b[k], op_a[k]}), .cin(c_ci[k]),
            .sub_en(c_sub), .sload(1'b0), .sclr(1'b0), .load_val(1'b0),
            .chain_in(c_ch[k]), .comb_out(c_sum[k]), .lut_chain_out(c_lc[k]),
            .cout(c_co[k]), .reg_out(c_q[k]), .chain_out(c_ch[k+1])
        );
        assign c_ci[k+1] = c_co[k];
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // word: {truth[15:0], arith, chain_sel, cin_sel, fb_sel}
    task automatic load_cfg(input logic [19:0] w, input bit to_chain);
        for (int i = 19; i >= 0; i--) begin
            @(negedge clk);
            cfg_din = w[i];
            if (to_chain) cfg_en_c = 1'b1; else cfg_en_s = 1'b1;
        end
        @(negedge clk);
        cfg_en_s = 1'b0;
        cfg_en_c = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!done) begin
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] tt;
        repeat (2) @(negedge clk);
        #1;
        check("R1 reset comb", comb_out, 0);
        check("R10 reset reg", reg_out, 0);
        check("R2 reset cout", cout, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1/R2: two unrelated tables, every index
        for (int t = 0; t < 2; t++) begin
            tt = (t == 0) ? 16'hA5C3 : 16'h1E74;
            load_cfg({tt, 4'b0000}, 0);
            for (int i = 0; i < 16; i++) begin
                @(negedge clk);
                d = i[3:0]; cin = 1'b1;
                #1;
                check("R1 R2 normal lookup", comb_out, tt[i]);
                check("R2 lut chain out", lchain, tt[i]);
                check("R2 normal cout", cout, 0);
            end
        end

        // R3: carry replaces data_in[2]
        tt = 16'h6B2D;
        load_cfg({tt, 4'b0010}, 0);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            d = i[3:0]; cin = i[4];
            #1;
            check("R3 cin substitute", comb_out, tt[{i[3], i[4], i[1], i[0]}]);
        end

        // R4: register replaces data_in[3]
        tt = 16'h8E3B;
        load_cfg({tt, 4'b0001}, 0);
        for (int r = 0; r < 2; r++) begin
            @(negedge clk);
            clk_en = 1'b1; sload = 1'b1; load_val = r[0];
            @(negedge clk);
            clk_en = 1'b0; sload = 1'b0;
            for (int i = 0; i < 16; i++) begin
                @(negedge clk);
                d = i[3:0];
                #1;
                check("R4 feedback substitute", comb_out, tt[{r[0], i[2:0]}]);
            end
        end

        // R5: default adder table and an arbitrary split table
        for (int t = 0; t < 2; t++) begin
            tt = (t == 0) ? 16'hE896 : 16'h3C5A;
            load_cfg({tt, 4'b1000}, 0);
            for (int i = 0; i < 16; i++) begin
                logic bb, s_e, c_e;
                @(negedge clk);
                d = {2'b11, i[1], i[0]}; cin = i[2]; sub = i[3];
                bb = i[1] ^ i[3];
                if (t == 0) begin
                    s_e = i[0] ^ bb ^ i[2];
                    c_e = (i[0] + bb + i[2]) > 1;
                end else begin
                    s_e = tt[{1'b0, i[2], bb, i[0]}];
                    c_e = tt[{1'b1, i[2], bb, i[0]}];
                end
                #1;
                check("R5 arith sum", comb_out, s_e);
                check("R5 arith carry", cout, c_e);
            end
        end
        sub = 1'b0;

        // R6: four-cell adder/subtractor, all operand pairs
        load_cfg({16'hE896, 4'b1000}, 1);
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    int full;
                    @(negedge clk);
                    op_a = a[3:0]; op_b = b[3:0]; c_sub = s[0];
                    #1;
                    if (s == 0) begin
                        full = a + b;
                        check("R6 add", {c_co[3], c_sum}, full[4:0]);
                    end else begin
                        full = (a - b) & 15;
                        check("R6 sub", {c_co[3], c_sum}, {(a >= b) ? 1'b1 : 1'b0, full[3:0]});
                    end
                end
            end
        end
        c_sub = 1'b0;

        // R7: capture with enable, hold without
        tt = 16'h5A0F;
        load_cfg({tt, 4'b0000}, 0);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            d = i[3:0]; clk_en = 1'b1;
            @(negedge clk);
            check("R7 register capture", reg_out, tt[i]);
        end
        @(negedge clk);
        d = 4'd0; clk_en = 1'b1;
        @(negedge clk);
        clk_en = 1'b0;
        d = 4'd1; sload = 1'b1; load_val = 1'b1; sclr = 1'b0;
        @(negedge clk);
        check("R7 hold when disabled", reg_out, tt[0]);
        sload = 1'b0; sclr = 1'b1;
        @(negedge clk);
        check("R7 hold vs clear", reg_out, tt[0]);

        // R8: clear priority, load value
        sclr = 1'b0; clk_en = 1'b1; sload = 1'b1; load_val = 1'b1;
        @(negedge clk);
        check("R8 load one", reg_out, 1);
        sclr = 1'b1;
        @(negedge clk);
        check("R8 clear beats load", reg_out, 0);
        sclr = 1'b0; load_val = 1'b0;
        @(negedge clk);
        check("R8 load zero", reg_out, 0);
        sload = 1'b0; clk_en = 1'b0;

        // R9: chained shift register
        load_cfg({16'hFFFF, 4'b0100}, 1);
        begin
            logic [3:0] pat;
            pat = 4'b1101;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                c_ser = pat[i]; c_en = 1'b1;
            end
            @(negedge clk);
            c_en = 1'b0;
            for (int k = 0; k < 4; k++) begin
                check("R9 chain capture", c_q[k], pat[3-k]);
                check("R9 chain out", c_ch[k+1], pat[3-k]);
            end
        end

        // R10: asynchronous clear
        @(negedge clk);
        clk_en = 1'b1; sload = 1'b1; load_val = 1'b1;
        @(negedge clk);
        clk_en = 1'b0; sload = 1'b0;
        check("R10 preset before clear", reg_out, 1);
        #2;
        rst_n = 1'b0;
        #1;
        check("R10 async clear", reg_out, 0);
        check("R1 cfg cleared", comb_out, 0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule